// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder with Non-Maskable Recognition

This block gathers a bank of peripheral interrupt request lines and reduces them, once per clock, to the single request that the processor should see. Each line has a fixed priority level from 1 to 7 and a fixed slot within that level. A per-line blocking register can silence any line. A small software register can inject requests at levels 1, 2 and 3. The winner's level is presented as a 3-bit code, with 0 meaning nothing is pending, together with its 8-bit vector number.

The block also contains the processor-side recognition logic. Levels 1 to 6 are compared against a 3-bit processor priority mask and are taken while they exceed it. Level 7 bypasses the mask, but it is recognized only on a change: the level code moving into 7, or the mask leaving 7 while the code stays at 7. Each such change produces a one-cycle non-maskable pulse. A one-word write port loads the blocking and inject registers.

Top module: `irq_level_encoder`

## Requirements
- R1: After synchronous reset, `irq_level`, `irq_vector`, `irq_take` and `nmi_take` are 0, the inject register is cleared and the blocking register is all zeros, so every line is enabled.
- R2: `irq_level` is registered one clock after the inputs it reflects and equals the highest level among pending, unblocked requests, or 0 when there are none. A higher level always wins over any slot of a lower level.
- R3: Request line i has level 7 - i/4 and slot 7 - (i mod 4). Within one level the higher slot wins, so a lower line index wins.
- R4: `irq_vector` is registered together with `irq_level`. It is 64 + i for line i, 112 + k for inject bit k, and 0 when `irq_level` is 0.
- R5: A write with `wr_sel`=0 loads `wr_data` into the blocking register, taking effect from the next clock. A set bit i hides line i at every level, including level 7.
- R6: A write with `wr_sel`=1 loads `wr_data[2:0]` into the inject register. Bit k requests level k+1 at slot 0 with vector 112 + k, and it loses to any line at the same level.
- R7: `irq_take` is high one clock after `irq_level` holds a value L in 1..6 with L greater than `cpu_mask`. It is never raised for level 7 or level 0.
- R8: `nmi_take` pulses for one clock after `irq_level` changes into 7 from any other value, whatever `cpu_mask` holds.
- R9: `nmi_take` pulses when `cpu_mask` changes from 7 to any lower value while `irq_level` stays at 7.
- R10: While `irq_level` stays at 7 and `cpu_mask` does not leave 7, no further `nmi_take` pulse occurs.
- R11: The stored previous level and previous mask reset to 0, so a level-7 request present right after reset produces exactly one `nmi_take` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 24 | Peripheral request lines, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 blocking register, 1 inject register |
| wr_data | input | 24 | Write data |
| cpu_mask | input | 3 | Processor priority mask |
| irq_level | output | 3 | Encoded level of the winning request, 0 when idle |
| irq_vector | output | 8 | Vector number of the winning request |
| irq_take | output | 1 | Maskable request accepted by the processor model |
| nmi_take | output | 1 | One-cycle non-maskable recognition pulse |

## Verification
Both non-maskable triggers can fall on the same clock: the level code entering 7 while the processor mask drops out of 7. The bench raises a level-7 request and lowers the mask in the same cycle, which must yield exactly one pulse. It then repeats the case with the mask drop one cycle late, which must yield two back-to-back pulses. Every cycle is compared against a scoreboard model, so a missing, merged or doubled pulse is reported against the requirement that covers it.

// File: rtl/irqenc_pkg.sv
package irqenc_pkg;

    localparam int LVL_W   = 3;
    localparam int SLOT_W  = 3;
    localparam int VEC_W   = 8;
    localparam int N_FORCE = 3;
    localparam int KEY_W   = LVL_W + SLOT_W;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [KEY_W-1:0]  key_t;

    typedef enum logic {
        SEL_MASK  = 1'b0,
        SEL_FORCE = 1'b1
    } wsel_e;

    typedef struct packed {
        logic  valid;
        lvl_t  lvl;
        slot_t slot;
        vec_t  vec;
    } cand_t;

    localparam lvl_t LVL_NMI = lvl_t'(7);

    function automatic lvl_t src_level(input int idx, input int per_lvl);
        return lvl_t'(7 - idx / per_lvl);
    endfunction

    function automatic slot_t src_slot(input int idx, input int per_lvl);
        return slot_t'(7 - idx % per_lvl);
    endfunction

    function automatic key_t cand_key(input cand_t c);
        return {c.lvl, c.slot};
    endfunction

    // Pick the stronger of two candidates; an invalid one always loses.
    function automatic cand_t pick_better(input cand_t a, input cand_t b);
        if (!b.valid) return a;
        if (!a.valid) return b;
        return (cand_key(b) > cand_key(a)) ? b : a;
    endfunction

endpackage

// File: rtl/irqenc_regs.sv
module irqenc_regs
    import irqenc_pkg::*;
#(
    parameter int NUM_REQ = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  wsel_e              wr_sel,
    input  logic [NUM_REQ-1:0] wr_data,
    output logic [NUM_REQ-1:0] mask_q,
    output logic [N_FORCE-1:0] force_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            force_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_MASK) begin
                mask_q <= wr_data;
            end else begin
                force_q <= wr_data[N_FORCE-1:0];
            end
        end
    end

    assert_mask_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_MASK) |=> mask_q == $past(wr_data));

    assert_force_write_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_FORCE) |=> force_q == $past(wr_data[N_FORCE-1:0]));

    assert_force_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(force_q));

endmodule

// File: rtl/irqenc_arb.sv
module irqenc_arb
    import irqenc_pkg::*;
#(
    parameter int NUM_REQ      = 24,
    parameter int PER_LVL      = 4,
    parameter int VEC_BASE     = 64,
    parameter int FRC_VEC_BASE = 112
) (
    input  logic [NUM_REQ-1:0] req,
    input  logic [NUM_REQ-1:0] mask,
    input  logic [N_FORCE-1:0] force_req,
    output cand_t              winner
);

    localparam int N_CAND = NUM_REQ + N_FORCE;

    cand_t cands [N_CAND];

    // Peripheral lines: fixed level and slot derived from the index (R3).
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_src
        assign cands[i] = cand_t'{
            valid: req[i] & ~mask[i],
            lvl:   src_level(i, PER_LVL),
            slot:  src_slot(i, PER_LVL),
            vec:   vec_t'(VEC_BASE + i)
        };
    end

    // Software inject bits: level k+1, lowest slot (R6).
    for (genvar k = 0; k < N_FORCE; k++) begin : g_frc
        assign cands[NUM_REQ + k] = cand_t'{
            valid: force_req[k],
            lvl:   lvl_t'(k + 1),
            slot:  slot_t'(0),
            vec:   vec_t'(FRC_VEC_BASE + k)
        };
    end

    always_comb begin
        cand_t best;
        best = '0;
        for (int j = 0; j < N_CAND; j++) begin
            best = pick_better(best, cands[j]);
        end
        winner = best;
    end

endmodule

// File: rtl/irqenc_recog.sv
module irqenc_recog
    import irqenc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  lvl_t lvl,
    input  lvl_t cpu_mask,
    output logic irq_take,
    output logic nmi_take
);

    lvl_t prev_lvl_q;
    lvl_t prev_mask_q;
    logic lvl7_now;
    logic lvl7_entered;
    logic mask_left7;

    assign lvl7_now     = (lvl == LVL_NMI);
    assign lvl7_entered = lvl7_now && (prev_lvl_q != LVL_NMI);
    assign mask_left7   = lvl7_now && (prev_mask_q == LVL_NMI) && (cpu_mask != LVL_NMI);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl_q  <= '0;
            prev_mask_q <= '0;
            irq_take    <= 1'b0;
            nmi_take    <= 1'b0;
        end else begin
            prev_lvl_q  <= lvl;
            prev_mask_q <= cpu_mask;
            irq_take    <= (lvl != '0) && !lvl7_now && (lvl > cpu_mask);
            nmi_take    <= lvl7_entered || mask_left7;
        end
    end

    assert_take_maskable_R7: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> ($past(lvl) != 3'd7 && $past(lvl) > $past(cpu_mask)));

    assert_nmi_needs_lvl7_R8: assert property (@(posedge clk) disable iff (rst)
        nmi_take |-> $past(lvl) == 3'd7);

    assert_nmi_mask_drop_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(lvl) == 3'd7 && $past(lvl, 2) == 3'd7 &&
         $past(cpu_mask, 2) == 3'd7 && $past(cpu_mask) != 3'd7) |-> nmi_take);

    assert_nmi_quiet_held_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(lvl) == 3'd7 && $past(lvl, 2) == 3'd7 &&
         $past(cpu_mask) == $past(cpu_mask, 2)) |-> !nmi_take);

endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder
    import irqenc_pkg::*;
#(
    parameter int NUM_REQ      = 24,
    parameter int PER_LVL      = 4,
    parameter int VEC_BASE     = 64,
    parameter int FRC_VEC_BASE = 112
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] irq_req,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [NUM_REQ-1:0] wr_data,
    input  logic [2:0]         cpu_mask,
    output logic [2:0]         irq_level,
    output logic [7:0]         irq_vector,
    output logic               irq_take,
    output logic               nmi_take
);

    logic [NUM_REQ-1:0] mask_q;
    logic [N_FORCE-1:0] force_q;
    cand_t              winner;
    lvl_t               lvl_q;
    vec_t               vec_q;

    irqenc_regs #(
        .NUM_REQ (NUM_REQ)
    ) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wsel_e'(wr_sel)),
        .wr_data (wr_data),
        .mask_q  (mask_q),
        .force_q (force_q)
    );

    irqenc_arb #(
        .NUM_REQ      (NUM_REQ),
        .PER_LVL      (PER_LVL),
        .VEC_BASE     (VEC_BASE),
        .FRC_VEC_BASE (FRC_VEC_BASE)
    ) arb_i (
        .req       (irq_req),
        .mask      (mask_q),
        .force_req (force_q),
        .winner    (winner)
    );

    // Re-evaluated every cycle; one register stage to the outputs (R2, R4).
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            vec_q <= '0;
        end else begin
            lvl_q <= winner.valid ? winner.lvl : '0;
            vec_q <= winner.valid ? winner.vec : '0;
        end
    end

    irqenc_recog recog_i (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl_q),
        .cpu_mask (cpu_mask),
        .irq_take (irq_take),
        .nmi_take (nmi_take)
    );

    assign irq_level  = lvl_q;
    assign irq_vector = vec_q;

    assert_idle_vector_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_level == 3'd0) |-> (irq_vector == 8'd0));

    assert_idle_inputs_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_req) == '0 && $past(force_q) == '0) |-> irq_level == 3'd0);

endmodule

// File: tb/irq_level_encoder_tb_top.sv
`timescale 1ns/1ps
module irq_level_encoder_tb_top;

    localparam int NR = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NR-1:0] irq_req = '0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [NR-1:0] wr_data = '0;
    logic [2:0]    cpu_mask = '0;
    logic [2:0]    irq_level;
    logic [7:0]    irq_vector;
    logic          irq_take;
    logic          nmi_take;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_level_encoder dut_i (
        .clk        (clk),
        .rst        (rst),
        .irq_req    (irq_req),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .cpu_mask   (cpu_mask),
        .irq_level  (irq_level),
        .irq_vector (irq_vector),
        .irq_take   (irq_take),
        .nmi_take   (nmi_take)
    );

    typedef struct {
        int         due;
        int         tag;
        logic [2:0] lvl;
        logic [7:0] vec;
        logic       take;
        logic       nmi;
    } exp_t;

    exp_t sbq[$];

    // Reference state built from the requirements only.
    logic [NR-1:0] m_mask  = '0;
    logic [2:0]    m_force = '0;
    logic [2:0]    m_l1    = '0;
    logic [2:0]    m_l2    = '0;
    logic [2:0]    m_cprev = '0;

    function automatic logic [NR-1:0] bitv(input int i);
        logic [NR-1:0] b;
        b = '0;
        b[i] = 1'b1;
        return b;
    endfunction

    // R3: line i has level 7 - i/4; lower index wins. R6: inject bit k is level k+1, loses ties.
    function automatic void ref_model(input logic [NR-1:0] r, input logic [NR-1:0] m,
                                      input logic [2:0] f,
                                      output logic [2:0] l, output logic [7:0] v);
        l = '0;
        v = '0;
        for (int i = 0; i < NR; i++) begin
            if (r[i] && !m[i]) begin
                l = 3'(7 - i / 4);
                v = 8'(64 + i);
                break;
            end
        end
        for (int k = 2; k >= 0; k--) begin
            if (f[k] && (k + 1) > int'(l)) begin
                l = 3'(k + 1);
                v = 8'(112 + k);
                break;
            end
        end
    endfunction

    task automatic chk(input string what, input int tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: one clock of stimulus, pushes the expected outputs for the next sample point.
    task automatic step(input logic [NR-1:0] r, input logic [2:0] cm, input int tag,
                        input logic we = 1'b0, input logic ws = 1'b0,
                        input logic [NR-1:0] wd = '0);
        exp_t e;
        logic [2:0] lk;
        logic [7:0] vk;
        @(negedge clk);
        irq_req  = r;
        cpu_mask = cm;
        wr_en    = we;
        wr_sel   = ws;
        wr_data  = wd;
        ref_model(r, m_mask, m_force, lk, vk);
        e.due  = cyc + 1;
        e.tag  = tag;
        e.lvl  = lk;
        e.vec  = vk;
        e.take = (m_l1 >= 3'd1) && (m_l1 <= 3'd6) && (m_l1 > cm);
        e.nmi  = (m_l1 == 3'd7) && ((m_l2 != 3'd7) || (m_cprev == 3'd7 && cm != 3'd7));
        sbq.push_back(e);
        m_l2    = m_l1;
        m_l1    = lk;
        m_cprev = cm;
        if (we) begin
            if (ws) m_force = wd[2:0];
            else    m_mask  = wd;
        end
    endtask

    // Monitor: compares every due item against the ports.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            chk("irq_level",  e.tag, int'(irq_level),  int'(e.lvl));
            chk("irq_vector", e.tag, int'(irq_vector), int'(e.vec));
            chk("irq_take",   e.tag, int'(irq_take),   int'(e.take));
            chk("nmi_take",   e.tag, int'(nmi_take),   int'(e.nmi));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk("reset irq_level",  1, int'(irq_level),  0);
        chk("reset irq_vector", 1, int'(irq_vector), 0);
        chk("reset irq_take",   1, int'(irq_take),   0);
        chk("reset nmi_take",   1, int'(nmi_take),   0);

        // R11: level-7 line right after reset gives one pulse; R10 while held
        repeat (4) step(bitv(0), 3'd0, 11);
        repeat (2) step('0, 3'd0, 1);

        // R2 and R4: single level-5 line (index 10, vector 74), R7 take with mask 0
        repeat (3) step(bitv(10), 3'd0, 4);
        // R2: level 5 beats level 2
        repeat (2) step(bitv(10) | bitv(20), 3'd0, 2);
        // R3: same level, index 9 beats index 10
        repeat (2) step(bitv(9) | bitv(10), 3'd0, 3);

        // R5: block line 9, line 10 then wins
        step(bitv(9) | bitv(10), 3'd0, 5, 1'b1, 1'b0, bitv(9));
        repeat (2) step(bitv(9) | bitv(10), 3'd0, 5);
        // R5: block a level-7 line; nothing pending
        step(bitv(0), 3'd0, 5, 1'b1, 1'b0, bitv(0));
        repeat (3) step(bitv(0), 3'd0, 5);
        step('0, 3'd0, 5, 1'b1, 1'b0, '0);

        // R6: all inject bits, level 3 vector 114
        step('0, 3'd0, 6, 1'b1, 1'b1, 24'h7);
        repeat (2) step('0, 3'd0, 6);
        // R6: inject level 3 vs line 20 (level 2): inject wins
        repeat (2) step(bitv(20), 3'd0, 6);
        // R6: inject level 1 only; line 20 then wins; alone gives vector 112
        step(bitv(20), 3'd0, 6, 1'b1, 1'b1, 24'h1);
        repeat (2) step(bitv(20), 3'd0, 6);
        repeat (2) step('0, 3'd0, 6);
        // R6: line 16 (level 3 slot 7) beats inject level 3
        step(bitv(16), 3'd0, 6, 1'b1, 1'b1, 24'h4);
        repeat (2) step(bitv(16), 3'd0, 6);
        step('0, 3'd0, 6, 1'b1, 1'b1, '0);

        // R7: level 5 against masks 5, 4, 7
        repeat (2) step(bitv(10), 3'd5, 7);
        repeat (2) step(bitv(10), 3'd4, 7);
        repeat (2) step(bitv(10), 3'd7, 7);
        step('0, 3'd0, 7);

        // R8: entry into 7 while the mask is 7
        repeat (3) step(bitv(1), 3'd7, 8);
        // R9: mask leaves 7 with level held
        repeat (2) step(bitv(1), 3'd3, 9);
        // R10: mask changes that do not leave 7
        repeat (2) step(bitv(1), 3'd2, 10);
        repeat (2) step(bitv(1), 3'd7, 10);
        // R8: 7 -> 6 -> 7
        step(bitv(4), 3'd7, 8);
        repeat (2) step(bitv(0), 3'd7, 8);
        repeat (2) step('0, 3'd7, 8);

        // R8 with R9 on one clock: entry into 7 as the mask drops from 7 -> one pulse
        step(bitv(0), 3'd7, 9);
        repeat (3) step(bitv(0), 3'd2, 9);
        step('0, 3'd7, 9);
        // R9: mask drop one cycle late -> two back-to-back pulses
        repeat (2) step(bitv(0), 3'd7, 9);
        repeat (3) step(bitv(0), 3'd2, 9);

        repeat (4) step('0, 3'd0, 1);
        while (sbq.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule